// File: doc/BRIEF.md
# Pipelined Floating-Point Divide Unit with Issue-Interval Interlock

This block divides one 32-bit single-precision operand by another inside a vector coprocessor. It runs next to the lane multiply-accumulate units and does not depend on them. A caller offers a divide by raising `issue_valid` with the two operands. The unit takes the request only while `busy` is low. Once a request is taken, `busy` stays high long enough to enforce a minimum spacing between taken requests. The quotient appears on `quotient`, with a one-cycle `result_valid` pulse, a fixed number of cycles later.

The pipeline is deeper than the issue spacing, so two divides can be in flight at the same time. The mantissa quotient comes from a restoring divider. Its quotient bits are shared out over the middle stages of the pipeline. The first stage unpacks the operands and the last stage packs the result. The arithmetic is simpler than the full standard. Subnormal inputs count as zero. The quotient is truncated. Division by zero saturates to the largest finite value and sets a flag that stays set until reset.

Top module: `fdiv_unit`

## Requirements
- R1: A request is taken on a rising edge where `issue_valid` is high and `busy` is low. After a taken request, `busy` reads high in each of the next six cycles and low in the seventh, so taken requests are at least seven cycles apart.
- R2: A request presented while `busy` is high is dropped and never produces a result.
- R3: Each taken request gives exactly one `result_valid` pulse, one cycle wide, in the ninth cycle after the cycle in which it was taken. Two requests taken seven cycles apart both complete, in order.
- R4: For nonzero operands, the quotient sign is the XOR of the operand sign bits (bit 31). The biased exponent (bits 30:23) is dividend exponent minus divisor exponent plus 127, or plus 126 when the dividend significand is smaller than the divisor significand. The fraction (bits 22:0) is the truncated normalised significand ratio. An exponent field of 255 is treated as an ordinary exponent.
- R5: Any operand whose exponent field is 0 is treated as zero, whatever its fraction bits.
- R6: A zero divisor gives 0x7F7FFFFF with the XOR sign in bit 31, and this holds even when the dividend is also zero. `dbz_flag` goes high in the cycle that result is delivered and stays high until reset.
- R7: A zero dividend with a nonzero divisor gives a zero whose sign is the XOR of the operand signs.
- R8: A biased result exponent above 254 saturates to the largest finite magnitude with the XOR sign. A biased result exponent below 1 gives a signed zero. The result exponent field is never 255.
- R9: Reset clears `busy`, `result_valid` and `dbz_flag`. A divide in flight when reset is asserted never produces a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| issue_valid | input | 1 | Divide request |
| dividend | input | 32 | Single-precision dividend |
| divisor | input | 32 | Single-precision divisor |
| busy | output | 1 | High while a new request would be refused |
| result_valid | output | 1 | One-cycle pulse marking a valid quotient |
| quotient | output | 32 | Single-precision quotient |
| dbz_flag | output | 1 | Sticky divide-by-zero indication |

## Verification
The single-pulse and spacing properties assume that requests reach the pipeline only through the interlock. The remainder bound assumes that both significands carry a set implicit leading bit, including the zero-operand cases. No assertion constrains operand values, so the stimulus covers exponent fields of 0 and 255, subnormals, and values near overflow and underflow. The bench changes inputs only at mid-cycle. It holds `issue_valid` high through a whole busy window to show that the extra requests are dropped, and it asserts reset while a divide is in flight.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int WORD_W      = 32;
  localparam int EXP_W       = 8;
  localparam int FRAC_W      = 23;
  localparam int SIG_W       = FRAC_W + 1;
  localparam int EXPI_W      = EXP_W + 2;
  localparam int BIAS        = 127;
  localparam int EXP_MAX_FIN = 254;

  typedef struct packed {
    logic              sign;
    logic [EXPI_W-1:0] exp_diff;
    logic              zero;
    logic              dbz;
  } side_t;
endpackage

// File: rtl/fdiv_issue_gate.sv
module fdiv_issue_gate #(
  parameter int GAP = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_valid,
  output logic accept,
  output logic busy
);
  localparam int CNT_W = (GAP > 2) ? $clog2(GAP) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign busy   = (cnt_q != '0);
  assign accept = issue_valid & ~busy;

  always_comb begin
    cnt_n = cnt_q;
    if (accept)    cnt_n = RELOAD;
    else if (busy) cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R1: a taken request closes the window on the next cycle
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R1: the window never reopens early
  p_busy_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != CNT_W'(1)) |=> busy);
endmodule

// File: rtl/fdiv_unpack.sv
module fdiv_unpack
  import fdiv_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [SIG_W-1:0]  ma_o,
  output logic [SIG_W-1:0]  mb_o,
  output side_t             side_o
);
  logic [EXP_W-1:0] ea, eb;
  logic             a_zero, b_zero;

  assign ea     = a_i[WORD_W-2 -: EXP_W];
  assign eb     = b_i[WORD_W-2 -: EXP_W];
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);

  // implicit one kept even for zero operands so the divider stays bounded
  assign ma_o = {1'b1, a_i[FRAC_W-1:0]};
  assign mb_o = {1'b1, b_i[FRAC_W-1:0]};

  always_comb begin
    side_o.sign     = a_i[WORD_W-1] ^ b_i[WORD_W-1];
    side_o.exp_diff = {2'b00, ea} - {2'b00, eb};
    side_o.dbz      = b_zero;
    side_o.zero     = a_zero & ~b_zero;
  end
endmodule

// File: rtl/fdiv_div_stage.sv
module fdiv_div_stage
  import fdiv_pkg::*;
#(
  parameter int BPS = 4,
  parameter int QW  = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  logic [SIG_W:0]   rem_i,
  input  logic [SIG_W-1:0] dvs_i,
  input  logic [QW-1:0]    q_i,
  input  side_t            side_i,
  output logic             v_o,
  output logic [SIG_W:0]   rem_o,
  output logic [SIG_W-1:0] dvs_o,
  output logic [QW-1:0]    q_o,
  output side_t            side_o
);
  logic [SIG_W:0] rem_n;
  logic [QW-1:0]  q_n;

  always_comb begin
    rem_n = rem_i;
    q_n   = q_i;
    for (int k = 0; k < BPS; k++) begin
      if (rem_n >= {1'b0, dvs_i}) begin
        rem_n = rem_n - {1'b0, dvs_i};
        q_n   = {q_n[QW-2:0], 1'b1};
      end else begin
        q_n   = {q_n[QW-2:0], 1'b0};
      end
      rem_n = {rem_n[SIG_W-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      rem_o  <= rem_n;
      dvs_o  <= dvs_i;
      q_o    <= q_n;
      side_o <= side_i;
    end
  end

  // R4: partial remainder entering a stage is below twice the divisor
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |-> (rem_i < {dvs_i, 1'b0}));
endmodule

// File: rtl/fdiv_pack.sv
module fdiv_pack
  import fdiv_pkg::*;
#(
  parameter int QW = 28
) (
  input  logic [QW-1:0]     q_i,
  input  side_t             side_i,
  output logic [WORD_W-1:0] res_o
);
  logic signed [EXPI_W-1:0] e;
  logic [FRAC_W-1:0]        frac;

  assign e = $signed(side_i.exp_diff + (q_i[QW-1] ? EXPI_W'(BIAS) : EXPI_W'(BIAS - 1)));
  assign frac = q_i[QW-1] ? q_i[QW-2 -: FRAC_W] : q_i[QW-3 -: FRAC_W];

  generate
    if (QW > FRAC_W + 2) begin : g_spare
      logic unused_low;
      assign unused_low = ^q_i[QW-FRAC_W-3:0];
    end
  endgenerate

  always_comb begin
    if (side_i.dbz || e > $signed(EXPI_W'(EXP_MAX_FIN)))
      res_o = {side_i.sign, EXP_W'(EXP_MAX_FIN), {FRAC_W{1'b1}}};
    else if (side_i.zero || e < $signed(EXPI_W'(1)))
      res_o = {side_i.sign, {(WORD_W-1){1'b0}}};
    else
      res_o = {side_i.sign, e[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fdiv_unit.sv
module fdiv_unit
  import fdiv_pkg::*;
#(
  parameter int LATENCY   = 9,
  parameter int ISSUE_GAP = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [WORD_W-1:0] dividend,
  input  logic [WORD_W-1:0] divisor,
  output logic              busy,
  output logic              result_valid,
  output logic [WORD_W-1:0] quotient,
  output logic              dbz_flag
);
  localparam int DIV_STAGES = LATENCY - 2;
  localparam int BPS        = (SIG_W + 1 + DIV_STAGES - 1) / DIV_STAGES;
  localparam int QW         = BPS * DIV_STAGES;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic accept;

  fdiv_issue_gate #(.GAP(ISSUE_GAP)) u_gate (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .issue_valid (issue_valid),
    .accept      (accept),
    .busy        (busy)
  );

  logic [SIG_W-1:0] ma, mb;
  side_t            side_in;

  fdiv_unpack u_unpack (
    .a_i    (dividend),
    .b_i    (divisor),
    .ma_o   (ma),
    .mb_o   (mb),
    .side_o (side_in)
  );

  // pipeline chain: entry 0 is the unpack register
  logic             v_c   [DIV_STAGES+1];
  logic [SIG_W:0]   rem_c [DIV_STAGES+1];
  logic [SIG_W-1:0] dvs_c [DIV_STAGES+1];
  logic [QW-1:0]    q_c   [DIV_STAGES+1];
  side_t            sd_c  [DIV_STAGES+1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) v_c[0] <= 1'b0;
    else            v_c[0] <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      rem_c[0] <= {1'b0, ma};
      dvs_c[0] <= mb;
      q_c[0]   <= '0;
      sd_c[0]  <= side_in;
    end
  end

  generate
    for (genvar s = 0; s < DIV_STAGES; s++) begin : g_stage
      fdiv_div_stage #(.BPS(BPS), .QW(QW)) u_stage (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .v_i    (v_c[s]),
        .rem_i  (rem_c[s]),
        .dvs_i  (dvs_c[s]),
        .q_i    (q_c[s]),
        .side_i (sd_c[s]),
        .v_o    (v_c[s+1]),
        .rem_o  (rem_c[s+1]),
        .dvs_o  (dvs_c[s+1]),
        .q_o    (q_c[s+1]),
        .side_o (sd_c[s+1])
      );
    end
  endgenerate

  logic unused_tail;
  assign unused_tail = ^{rem_c[DIV_STAGES], dvs_c[DIV_STAGES]};

  logic [WORD_W-1:0] res_n;

  fdiv_pack #(.QW(QW)) u_pack (
    .q_i    (q_c[DIV_STAGES]),
    .side_i (sd_c[DIV_STAGES]),
    .res_o  (res_n)
  );

  logic out_v_q, flag_q, flag_n;
  logic [WORD_W-1:0] res_q;

  assign flag_n = flag_q | (v_c[DIV_STAGES] & sd_c[DIV_STAGES].dbz);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_v_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      out_v_q <= v_c[DIV_STAGES];
      flag_q  <= flag_n;
    end
  end

  always_ff @(posedge clk) begin
    if (v_c[DIV_STAGES]) res_q <= res_n;
  end

  assign result_valid = out_v_q;
  assign quotient     = res_q;
  assign dbz_flag     = flag_q;

  // R3: issue spacing keeps results from arriving back to back
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    result_valid |=> !result_valid);
  // R8: no infinity or NaN encoding ever leaves the unit
  p_finite_out_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    result_valid |-> (quotient[WORD_W-2 -: EXP_W] != {EXP_W{1'b1}}));
  // R6: the divide-by-zero flag never clears on its own
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    dbz_flag |=> dbz_flag);
  // R6: the flag rises only together with a saturated result
  p_flag_value_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(dbz_flag) |-> (result_valid && quotient[WORD_W-2:0] == 31'h7F7FFFFF));
endmodule

// File: tb/fdiv_unit_bench.sv
module fdiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [31:0] dividend, divisor;
  logic        busy, result_valid, dbz_flag;
  logic [31:0] quotient;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fdiv_unit u_fdiv_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_valid  (issue_valid),
    .dividend     (dividend),
    .divisor      (divisor),
    .busy         (busy),
    .result_valid (result_valid),
    .quotient     (quotient),
    .dbz_flag     (dbz_flag)
  );

  // {dividend, divisor, expected quotient, divide-by-zero expected}
  localparam int NV = 16;
  localparam logic [96:0] VEC [NV] = '{
    {32'h40C00000, 32'h40000000, 32'h40400000, 1'b0},
    {32'h3F800000, 32'h40400000, 32'h3EAAAAAA, 1'b0},
    {32'hC0F00000, 32'h40200000, 32'hC0400000, 1'b0},
    {32'h3F800000, 32'hBF000000, 32'hC0000000, 1'b0},
    {32'h40000000, 32'h40400000, 32'h3F2AAAAA, 1'b0},
    {32'h3FFFFFFF, 32'h3F800000, 32'h3FFFFFFF, 1'b0},
    {32'h7F800000, 32'h7F000000, 32'h40000000, 1'b0},
    {32'h80000000, 32'h40000000, 32'h80000000, 1'b0},
    {32'h00000001, 32'h3F800000, 32'h00000000, 1'b0},
    {32'h7F000000, 32'h3E800000, 32'h7F7FFFFF, 1'b0},
    {32'h00800000, 32'h40000000, 32'h00000000, 1'b0},
    {32'hFF000000, 32'h3E800000, 32'hFF7FFFFF, 1'b0},
    {32'h3F800000, 32'h00400000, 32'h7F7FFFFF, 1'b1},
    {32'h3F800000, 32'h80000000, 32'hFF7FFFFF, 1'b1},
    {32'h00000000, 32'h00000000, 32'h7F7FFFFF, 1'b1},
    {32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0}
  };

  function automatic string vec_tag(input int i);
    case (i)
      7:          return "R7";
      8, 12:      return "R5";
      9, 10, 11:  return "R8";
      13, 14:     return "R6";
      default:    return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic early;
    logic flag_exp;
    rst_n = 1'b0; issue_valid = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: state out of reset
    check("R9", {29'd0, busy, result_valid, dbz_flag}, 32'd0);

    // table walk: one divide at a time, latency and value per vector
    flag_exp = 1'b0;
    for (int i = 0; i < NV; i++) begin
      dividend = VEC[i][96:65]; divisor = VEC[i][64:33]; issue_valid = 1'b1;
      @(negedge clk); issue_valid = 1'b0;
      early = 1'b0;
      for (int d = 1; d < 9; d++) begin
        if (result_valid) early = 1'b1;
        @(negedge clk);
      end
      check("R3", {30'd0, early, result_valid}, 32'd1);
      check(vec_tag(i), quotient, VEC[i][32:1]);
      flag_exp = flag_exp | VEC[i][0];
      check("R6", {31'd0, dbz_flag}, {31'd0, flag_exp});
    end

    // R1 and R3: busy window, then a second divide overlapping the first
    dividend = 32'h40C00000; divisor = 32'h40000000; issue_valid = 1'b1;
    @(negedge clk); issue_valid = 1'b0;
    early = 1'b0;
    for (int d = 1; d < 7; d++) begin
      if (!busy) early = 1'b1;
      @(negedge clk);
    end
    check("R1", {31'd0, early}, 32'd0);
    check("R1", {31'd0, busy}, 32'd0);
    dividend = 32'h3F800000; divisor = 32'h40400000; issue_valid = 1'b1;
    @(negedge clk); issue_valid = 1'b0;
    @(negedge clk);
    check("R3", {31'd0, result_valid}, 32'd1);
    check("R3", quotient, 32'h40400000);
    early = 1'b0;
    for (int d = 10; d < 16; d++) begin
      @(negedge clk);
      if (result_valid) early = 1'b1;
    end
    @(negedge clk);
    check("R3", {30'd0, early, result_valid}, 32'd1);
    check("R3", quotient, 32'h3EAAAAAA);

    // R2: request held through the busy window yields one result only
    dividend = 32'h40C00000; divisor = 32'h40000000; issue_valid = 1'b1;
    @(negedge clk);
    dividend = 32'h3F800000; divisor = 32'h40400000;
    for (int d = 2; d < 7; d++) @(negedge clk);
    @(negedge clk); issue_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2", {31'd0, result_valid}, 32'd1);
    check("R2", quotient, 32'h40400000);
    early = 1'b0;
    for (int d = 10; d < 17; d++) begin
      @(negedge clk);
      if (result_valid) early = 1'b1;
    end
    check("R2", {31'd0, early}, 32'd0);

    // R9: reset while a divide is in flight
    dividend = 32'h3F800000; divisor = 32'h00000000; issue_valid = 1'b1;
    @(negedge clk); issue_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", {29'd0, busy, result_valid, dbz_flag}, 32'd0);
    rst_n = 1'b1;
    early = 1'b0;
    for (int d = 0; d < 12; d++) begin
      @(negedge clk);
      if (result_valid || dbz_flag) early = 1'b1;
    end
    check("R9", {31'd0, early}, 32'd0);

    // post-reset divide still works
    dividend = 32'hBF800000; divisor = 32'h3F800000; issue_valid = 1'b1;
    @(negedge clk); issue_valid = 1'b0;
    repeat (8) @(negedge clk);
    check("R4", {31'd0, result_valid}, 32'd1);
    check("R4", quotient, 32'hBF800000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule